// File: doc/BRIEF.md
# Locked Read-Modify-Write Guard

This block sits between the instruction decoder and the bus unit. For every decoded instruction it is handed a descriptor made of a lock-prefix flag, an operation class, an operand form and a misalignment flag. It decides whether a lock prefix on that instruction is permitted. A prefix on a permitted form, or any exchange that touches memory, makes the block hold the active-low bus lock across every bus cycle of the read-modify-write. That includes the extra pieces of a misaligned operand. A prefix on any other form produces a one-cycle undefined-opcode trap, with a vector chosen by the processor mode, and no lock is taken.

Descriptors arrive on a valid/ready handshake. A descriptor transfers on a clock edge where `instr_valid` and `instr_ready` are both high. `instr_ready` stays low from the edge that accepts a locking instruction until the lock is released, and during that window the decoder must hold its descriptor. The block adds no cycles to instructions that do not lock. Bus strobes are plain pulses from the bus unit. A cycle counts toward release when its `bus_done` follows a `bus_start` seen while the lock is held. The block touches no flags, and exceptions raised by the locked instruction itself are not routed through it.

Top module: `bus_lock_guard`

## Requirements
- R1: After synchronous reset, `lock_n` is 1, `ud_trap` is 0, `trap_vector` is 0 and `instr_ready` is 1.
- R2: A prefixed instruction with operand form 0 (memory destination, register/immediate source or single memory operand) and an operation class from 0 to 15 is accepted without a trap, and `lock_n` is 0 from the accepting edge onward. The classes are: 0 bit test, 1 bit test-and-set, 2 bit test-and-reset, 3 bit test-and-complement, 4 exchange, 5 add, 6 or, 7 add-with-carry, 8 subtract-with-borrow, 9 and, 10 subtract, 11 xor, 12 not, 13 negate, 14 increment, 15 decrement. A prefixed exchange (class 4) with operand form 2 (register-memory exchange) is also accepted and locks.
- R3: A prefixed instruction of any other class/form pair raises `ud_trap` for exactly the one cycle after the accepting edge, and `lock_n` stays 1. This covers classes 16 to 31, form 1 (register destination) and form 3 (no memory operand).
- R4: With the trap, `trap_vector` carries `RM_VEC` (default 6) when `cpu_mode` was 0 (real-address) at acceptance, and `PM_VEC` (default 6) for modes 1 (protected), 2 (virtual-8086) and 3.
- R5: Without a prefix, an exchange (class 4) with form 0 or 2 still locks. Every other unprefixed instruction neither locks nor traps.
- R6: An aligned locked instruction holds the lock for 2 bus cycles (read then write), except bit test (class 0), which holds it for 1 read cycle.
- R7: With `misaligned` set, the held cycle count is multiplied by `SPLIT` (default 2). That gives 4 cycles for a read-modify-write and 2 for a misaligned bit test.
- R8: While the lock is held, `instr_ready` is 0 and any descriptor offered is ignored: it causes no trap and does not change the lock length.
- R9: `lock_n` returns to 1 on the clock edge that samples the final counted `bus_done`, and `instr_ready` returns to 1 on the same edge. Earlier `bus_done` strobes leave `lock_n` at 0.
- R10: A `bus_done` with no `bus_start` before it in the lock window does not count. While idle, `bus_done` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Descriptor valid |
| instr_ready | output | 1 | Block can accept a descriptor |
| lock_prefix | input | 1 | Lock prefix present on the instruction |
| op_class | input | 5 | Operation class code (see R2) |
| operand_form | input | 2 | 0 mem dest, 1 reg dest, 2 reg-mem exchange, 3 no memory |
| misaligned | input | 1 | Memory operand splits across bus cycles |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086 |
| bus_start | input | 1 | Bus cycle start strobe |
| bus_done | input | 1 | Bus cycle completion strobe |
| lock_n | output | 1 | Active-low bus lock |
| ud_trap | output | 1 | One-cycle undefined-opcode trap pulse |
| trap_vector | output | 8 | Vector number for the trap |

## Verification
The bench walks every permitted class/form pair with the prefix and checks that each one locks and is released after exactly its bus-cycle count. A whitelist that is off by one class would trap a legal instruction or lock an illegal one. A wrong cycle count, or a misaligned access not multiplied, shows up as `lock_n` rising before the last `bus_done` or staying low after it. The bench also offers descriptors while a lock is held, sends stray done strobes, and sends unprefixed exchanges. A design that drops back-pressure would trap in the middle of a lock. One that counts unstarted cycles would release too early, and one that ignores forced exchange locking would leave `lock_n` high.

// File: rtl/lkc_pkg.sv
package lkc_pkg;

  localparam int CLASS_W = 5;
  localparam int FORM_W  = 2;
  localparam int MODE_W  = 2;

  typedef enum logic [CLASS_W-1:0] {
    OP_BT   = 5'd0,  OP_BTS  = 5'd1,  OP_BTR  = 5'd2,  OP_BTC  = 5'd3,
    OP_XCHG = 5'd4,  OP_ADD  = 5'd5,  OP_OR   = 5'd6,  OP_ADC  = 5'd7,
    OP_SBB  = 5'd8,  OP_AND  = 5'd9,  OP_SUB  = 5'd10, OP_XOR  = 5'd11,
    OP_NOT  = 5'd12, OP_NEG  = 5'd13, OP_INC  = 5'd14, OP_DEC  = 5'd15,
    OP_MOV  = 5'd16, OP_CMP  = 5'd17, OP_TEST = 5'd18, OP_LEA  = 5'd19
  } op_class_e;

  typedef enum logic [FORM_W-1:0] {
    FM_MEMDST  = 2'd0,
    FM_REGDST  = 2'd1,
    FM_XCHG_RM = 2'd2,
    FM_NOMEM   = 2'd3
  } form_e;

  typedef enum logic [MODE_W-1:0] {
    MD_REAL = 2'd0,
    MD_PROT = 2'd1,
    MD_V86  = 2'd2,
    MD_RSVD = 2'd3
  } mode_e;

  typedef struct packed {
    logic               pfx;
    logic [CLASS_W-1:0] cls;
    logic [FORM_W-1:0]  form;
    logic               mis;
  } desc_t;

endpackage

// File: rtl/lkc_rules.sv
module lkc_rules
  import lkc_pkg::*;
#(
  parameter int SPLIT = 2,
  localparam int MAXC  = 2 * SPLIT,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  desc_t            d,
  output logic             need_lock,
  output logic             bad_prefix,
  output logic [CNT_W-1:0] n_cycles
);

  logic rmw_class;
  logic is_xchg;
  logic xchg_mem;
  logic legal_form;
  int   base_len;

  always_comb begin
    rmw_class  = (d.cls <= CLASS_W'(OP_DEC));
    is_xchg    = (d.cls == CLASS_W'(OP_XCHG));
    xchg_mem   = is_xchg && ((d.form == FORM_W'(FM_MEMDST)) ||
                             (d.form == FORM_W'(FM_XCHG_RM)));
    legal_form = ((d.form == FORM_W'(FM_MEMDST)) && rmw_class) ||
                 ((d.form == FORM_W'(FM_XCHG_RM)) && is_xchg);
    need_lock  = d.pfx ? legal_form : xchg_mem;
    bad_prefix = d.pfx && !legal_form;
    base_len   = (d.cls == CLASS_W'(OP_BT)) ? 1 : 2;
  end

  generate
    if (SPLIT > 1) begin : g_split
      assign n_cycles = CNT_W'(d.mis ? base_len * SPLIT : base_len);
    end else begin : g_nosplit
      assign n_cycles = CNT_W'(base_len);
    end
  endgenerate

  always_comb begin
    a_r3_trap_only_prefixed : assert (!bad_prefix || d.pfx);
    a_r3_trap_excludes_lock : assert (!(bad_prefix && need_lock));
  end

endmodule

// File: rtl/lkc_seq.sv
module lkc_seq #(
  parameter int SPLIT = 2,
  localparam int MAXC  = 2 * SPLIT,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             need_lock,
  input  logic [CNT_W-1:0] n_cycles,
  input  logic             bus_start,
  input  logic             bus_done,
  output logic             lock_n,
  output logic             busy
);

  typedef enum logic {S_IDLE, S_HOLD} st_e;

  st_e              state;
  logic [CNT_W-1:0] remain;
  logic             in_cycle;
  logic             counted;

  assign counted = (state == S_HOLD) && bus_done && in_cycle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      remain   <= '0;
      in_cycle <= 1'b0;
      lock_n   <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          in_cycle <= 1'b0;
          if (accept && need_lock) begin
            state  <= S_HOLD;
            remain <= n_cycles;
            lock_n <= 1'b0;
          end
        end
        S_HOLD: begin
          if (counted) begin
            in_cycle <= bus_start;
            if (remain == CNT_W'(1)) begin
              state  <= S_IDLE;
              remain <= '0;
              lock_n <= 1'b1;
            end else begin
              remain <= remain - CNT_W'(1);
            end
          end else if (bus_start) begin
            in_cycle <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state == S_HOLD);

  a_r9_release_on_done : assert property (@(posedge clk) disable iff (rst)
    $rose(lock_n) |-> $past(bus_done));
  a_r2_lock_from_accept : assert property (@(posedge clk) disable iff (rst)
    $fell(lock_n) |-> $past(accept && need_lock));
  a_r9_hold_midway : assert property (@(posedge clk) disable iff (rst)
    (counted && remain > CNT_W'(1)) |=> !lock_n);
  a_r10_unstarted_done : assert property (@(posedge clk) disable iff (rst)
    (busy && bus_done && !in_cycle && !bus_start) |=> $stable(remain));
  a_r7_count_bound : assert property (@(posedge clk) disable iff (rst)
    busy |-> (remain != '0 && remain <= CNT_W'(MAXC)));

endmodule

// File: rtl/lkc_trap.sv
module lkc_trap
  import lkc_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int RM_VEC = 6,
  parameter int PM_VEC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              bad_prefix,
  input  logic [MODE_W-1:0] cpu_mode,
  output logic              ud_trap,
  output logic [VEC_W-1:0]  trap_vector
);

  logic [VEC_W-1:0] vec_sel;

  always_comb begin
    case (cpu_mode)
      MODE_W'(MD_REAL): vec_sel = VEC_W'(RM_VEC);
      default:          vec_sel = VEC_W'(PM_VEC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ud_trap     <= 1'b0;
      trap_vector <= '0;
    end else begin
      ud_trap <= accept && bad_prefix;
      if (accept && bad_prefix) trap_vector <= vec_sel;
    end
  end

  a_r3_trap_cause : assert property (@(posedge clk) disable iff (rst)
    ud_trap |-> $past(accept && bad_prefix));
  a_r4_vec_real : assert property (@(posedge clk) disable iff (rst)
    (ud_trap && $past(cpu_mode) == MODE_W'(MD_REAL)) |-> trap_vector == VEC_W'(RM_VEC));
  a_r4_vec_prot : assert property (@(posedge clk) disable iff (rst)
    (ud_trap && $past(cpu_mode) != MODE_W'(MD_REAL)) |-> trap_vector == VEC_W'(PM_VEC));

endmodule

// File: rtl/bus_lock_guard.sv
module bus_lock_guard
  import lkc_pkg::*;
#(
  parameter int SPLIT  = 2,
  parameter int VEC_W  = 8,
  parameter int RM_VEC = 6,
  parameter int PM_VEC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic               lock_prefix,
  input  logic [CLASS_W-1:0] op_class,
  input  logic [FORM_W-1:0]  operand_form,
  input  logic               misaligned,
  input  logic [MODE_W-1:0]  cpu_mode,
  input  logic               bus_start,
  input  logic               bus_done,
  output logic               lock_n,
  output logic               ud_trap,
  output logic [VEC_W-1:0]   trap_vector
);

  localparam int MAXC  = 2 * SPLIT;
  localparam int CNT_W = $clog2(MAXC + 1);

  desc_t            desc;
  logic             accept;
  logic             need_lock;
  logic             bad_prefix;
  logic             busy;
  logic [CNT_W-1:0] n_cycles;

  assign desc        = '{pfx: lock_prefix, cls: op_class, form: operand_form, mis: misaligned};
  assign instr_ready = !busy;
  assign accept      = instr_valid && instr_ready;

  lkc_rules #(.SPLIT(SPLIT)) u_rules (
    .d          (desc),
    .need_lock  (need_lock),
    .bad_prefix (bad_prefix),
    .n_cycles   (n_cycles)
  );

  lkc_seq #(.SPLIT(SPLIT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .need_lock (need_lock),
    .n_cycles  (n_cycles),
    .bus_start (bus_start),
    .bus_done  (bus_done),
    .lock_n    (lock_n),
    .busy      (busy)
  );

  lkc_trap #(.VEC_W(VEC_W), .RM_VEC(RM_VEC), .PM_VEC(PM_VEC)) u_trap (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .bad_prefix  (bad_prefix),
    .cpu_mode    (cpu_mode),
    .ud_trap     (ud_trap),
    .trap_vector (trap_vector)
  );

  a_r3_trap_no_lock : assert property (@(posedge clk) disable iff (rst)
    ud_trap |-> lock_n);
  a_r8_ready_while_locked : assert property (@(posedge clk) disable iff (rst)
    !lock_n |-> !instr_ready);
  a_r8_no_trap_when_busy : assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !instr_ready) |=> !ud_trap);

endmodule

// File: tb/test_bus_lock_guard.sv
module test_bus_lock_guard;

  logic       clk = 1'b0;
  logic       rst;
  logic       instr_valid, lock_prefix, misaligned, bus_start, bus_done;
  logic [4:0] op_class;
  logic [1:0] operand_form, cpu_mode;
  logic       instr_ready, lock_n, ud_trap;
  logic [7:0] trap_vector;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  bus_lock_guard i_bus_lock_guard (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .lock_prefix(lock_prefix), .op_class(op_class), .operand_form(operand_form),
    .misaligned(misaligned), .cpu_mode(cpu_mode), .bus_start(bus_start),
    .bus_done(bus_done), .lock_n(lock_n), .ud_trap(ud_trap), .trap_vector(trap_vector)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input bit pfx, input int cls, input int form, input bit mis, input int mode);
    @(negedge clk);
    instr_valid  = 1'b1;
    lock_prefix  = pfx;
    op_class     = 5'(cls);
    operand_form = 2'(form);
    misaligned   = mis;
    cpu_mode     = 2'(mode);
    @(posedge clk); #1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  // one bus cycle; returns lock_n sampled just after the edge that takes bus_done
  task automatic bus_cycle(output logic ln_after);
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
    @(negedge clk); bus_done = 1'b1;
    @(posedge clk); #1; ln_after = lock_n;
    @(negedge clk); bus_done = 1'b0;
  endtask

  task automatic run_locked(input bit pfx, input int cls, input int form, input bit mis,
                            input int ncyc, input string req);
    logic ln;
    @(negedge clk);
    instr_valid = 1'b1; lock_prefix = pfx; op_class = 5'(cls);
    operand_form = 2'(form); misaligned = mis; cpu_mode = 2'd1;
    @(posedge clk); #1;
    chk(lock_n == 1'b0, req, lock_n, 0);
    chk(instr_ready == 1'b0, req, instr_ready, 0);
    @(negedge clk); instr_valid = 1'b0;
    chk(ud_trap == 1'b0, req, ud_trap, 0);
    for (int k = 1; k <= ncyc; k++) begin
      bus_cycle(ln);
      if (k < ncyc) chk(ln == 1'b0, {req, " R9 mid"}, ln, 0);
      else          chk(ln == 1'b1, {req, " R9 last"}, ln, 1);
    end
    chk(instr_ready == 1'b1, {req, " R9 ready"}, instr_ready, 1);
  endtask

  task automatic t_reset;
    rst = 1'b1; instr_valid = 0; lock_prefix = 0; op_class = 0; operand_form = 0;
    misaligned = 0; cpu_mode = 0; bus_start = 0; bus_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(lock_n == 1'b1, "R1 lock_n", lock_n, 1);
    chk(ud_trap == 1'b0, "R1 ud_trap", ud_trap, 0);
    chk(trap_vector == 8'd0, "R1 vector", trap_vector, 0);
    chk(instr_ready == 1'b1, "R1 ready", instr_ready, 1);
  endtask

  task automatic t_whitelist;
    for (int c = 0; c < 16; c++)
      run_locked(1'b1, c, 0, 1'b0, (c == 0) ? 1 : 2, "R2 R6 memdst");
    run_locked(1'b1, 4, 2, 1'b0, 2, "R2 xchg reg-mem");
  endtask

  task automatic trap_case(input int cls, input int form, input int mode, input int vec, input string req);
    @(negedge clk);
    instr_valid = 1'b1; lock_prefix = 1'b1; op_class = 5'(cls);
    operand_form = 2'(form); misaligned = 1'b0; cpu_mode = 2'(mode);
    @(posedge clk); #1;
    chk(ud_trap == 1'b1, {req, " R3 pulse"}, ud_trap, 1);
    chk(lock_n == 1'b1, {req, " R3 nolock"}, lock_n, 1);
    chk(trap_vector == 8'(vec), {req, " R4 vector"}, trap_vector, vec);
    @(negedge clk); instr_valid = 1'b0;
    @(posedge clk); #1;
    chk(ud_trap == 1'b0, {req, " R3 one-cycle"}, ud_trap, 0);
    chk(lock_n == 1'b1, {req, " R3 still unlocked"}, lock_n, 1);
  endtask

  task automatic t_illegal;
    trap_case(16, 0, 1, 6, "mov memdst");
    trap_case(5, 1, 1, 6, "add regdst");
    trap_case(14, 3, 2, 6, "inc nomem");
    trap_case(4, 1, 1, 6, "xchg regdst");
    trap_case(17, 0, 2, 6, "cmp memdst");
    trap_case(9, 2, 1, 6, "and xchgform");
    trap_case(31, 0, 1, 6, "class31");
  endtask

  task automatic t_modes;
    trap_case(16, 0, 0, 6, "R4 real");
    trap_case(16, 0, 1, 6, "R4 prot");
    trap_case(16, 0, 2, 6, "R4 v86");
    trap_case(16, 0, 3, 6, "R4 mode3");
  endtask

  task automatic t_xchg_noprefix;
    run_locked(1'b0, 4, 0, 1'b0, 2, "R5 xchg mem,reg");
    run_locked(1'b0, 4, 2, 1'b0, 2, "R5 xchg reg-mem");
    run_locked(1'b0, 4, 2, 1'b1, 4, "R5 R7 xchg misaligned");
  endtask

  task automatic t_plain_noprefix;
    int clist[4] = '{5, 16, 0, 4};
    int flist[4] = '{0, 0, 0, 1};
    for (int i = 0; i < 4; i++) begin
      issue(1'b0, clist[i], flist[i], 1'b0, 1);
      chk(lock_n == 1'b1, "R5 plain no lock", lock_n, 1);
      chk(ud_trap == 1'b0, "R5 plain no trap", ud_trap, 0);
      chk(instr_ready == 1'b1, "R5 plain ready", instr_ready, 1);
    end
  endtask

  task automatic t_misaligned;
    run_locked(1'b1, 5, 0, 1'b1, 4, "R7 add misaligned");
    run_locked(1'b1, 0, 0, 1'b1, 2, "R7 bt misaligned");
    run_locked(1'b1, 13, 0, 1'b1, 4, "R7 neg misaligned");
    run_locked(1'b1, 3, 0, 1'b0, 2, "R6 btc aligned");
  endtask

  task automatic t_busy_ignore;
    logic ln;
    issue(1'b1, 5, 0, 1'b0, 1);
    chk(lock_n == 1'b0, "R8 locked", lock_n, 0);
    @(negedge clk);
    instr_valid = 1'b1; lock_prefix = 1'b1; op_class = 5'd16; operand_form = 2'd0;
    misaligned = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(instr_ready == 1'b0, "R8 ready low", instr_ready, 0);
      chk(ud_trap == 1'b0, "R8 offer ignored", ud_trap, 0);
    end
    @(negedge clk); instr_valid = 1'b0;
    bus_cycle(ln);
    chk(ln == 1'b0, "R8 length kept mid", ln, 0);
    bus_cycle(ln);
    chk(ln == 1'b1, "R8 length kept end", ln, 1);
  endtask

  task automatic t_stray_done;
    logic ln;
    @(negedge clk); bus_done = 1'b1;
    @(posedge clk); #1;
    chk(lock_n == 1'b1, "R10 idle done", lock_n, 1);
    chk(instr_ready == 1'b1, "R10 idle ready", instr_ready, 1);
    @(negedge clk); bus_done = 1'b0;
    issue(1'b1, 6, 0, 1'b0, 1);
    // done strobe without a start inside the lock window must not count
    @(negedge clk); bus_done = 1'b1;
    @(posedge clk); #1;
    chk(lock_n == 1'b0, "R10 unstarted done", lock_n, 0);
    @(negedge clk); bus_done = 1'b0;
    bus_cycle(ln);
    chk(ln == 1'b0, "R10 first real cycle", ln, 0);
    bus_cycle(ln);
    chk(ln == 1'b1, "R10 second real cycle", ln, 1);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_whitelist();
    t_illegal();
    t_modes();
    t_xchg_noprefix();
    t_plain_noprefix();
    t_misaligned();
    t_busy_ignore();
    t_stray_done();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule